// File: doc/BRIEF.md
# 3x3 Cluster Sparsification Engine

This block takes a frame of digitised pixel samples, one full row at a time, and reduces it to a short list of candidate particle hits. Each pixel is a 3-bit unsigned code. The block keeps three rows in registers: the row above the centre, the centre row and the row below it. It walks the centre row one column per cycle and looks at the 3x3 window around each position. A window is reported only when its centre pixel reaches a programmable seed level and the sum of its nine pixels reaches a programmable cluster level. Every other window is dropped.

Each accepted window leaves as one record on a valid/ready output. The record always holds the centre address. A build-time parameter selects how many pixel values go with it. Full mode carries the centre and its four edge-sharing neighbours. Reduced mode carries the centre and its brightest edge-sharing neighbour, which makes the record narrower. When the consumer stalls, the scan pauses and no record is lost. Overlapping windows are all reported separately; nothing merges them.

Top module: `cl_sparsifier`

## Requirements
- R1: A row is taken when `in_valid` and `in_ready` are both high at a clock edge. Column c of that row is `in_row[3c+2:3c]`. A frame is exactly ROWS rows, and the first row accepted after reset or after a finished frame is row 0.
- R2: A window is accepted only if its centre code is at least the seed level and the sum of its nine codes is at least the cluster level. Both comparisons include equality.
- R3: Neighbours that lie above row 0, below row ROWS-1, left of column 0 or right of column COLS-1 count as zero. Windows centred on the edge are still evaluated. Nothing from one frame leaks into the next.
- R4: Records come out in raster order: centre row ascending, then column ascending. The last row is evaluated without any further input once the final row of the frame has been taken.
- R5: In full mode (REDUCED=0) a record is, from MSB to LSB: centre, north (row-1), south (row+1), west (col-1), east (col+1), each 3 bits, then the centre row index (ROW_W bits), then the centre column index (COL_W bits).
- R6: In reduced mode (REDUCED=1) a record is, from MSB to LSB: centre, then the largest of north, south, west and east, then the row index, then the column index. On a tie the earliest of north, south, west, east in that order wins.
- R7: A clock edge with `cfg_we` high and `cfg_sel`=0 loads the seed level from `cfg_wdata[2:0]`. With `cfg_sel`=1 it loads the cluster level from `cfg_wdata[6:0]`.
- R8: While `o_valid` is high and `o_ready` is low, `o_valid` stays high and `o_rec` holds its value. Every accepted window is delivered exactly once.
- R9: After reset, `o_valid` is 0 and `in_ready` is 1, the seed level is 4 and the cluster level is 12.
- R10: Overlapping windows that each pass both tests are each reported as a separate record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | 0 selects the seed level, 1 selects the cluster level |
| cfg_wdata | input | 7 | Threshold write value |
| in_valid | input | 1 | Row data present |
| in_ready | output | 1 | Block can take a row |
| in_row | input | COLS*3 | One row of pixel codes, column 0 in the low bits |
| o_valid | output | 1 | Record present |
| o_ready | input | 1 | Consumer takes the record |
| o_rec | output | REC_W | Cluster record (pixel values, row, column) |

## Verification
The assertions assume the threshold levels are not written while a frame is in flight. This matters because the check on the centre code of an emitted record compares it against the current seed level. They also assume each frame holds exactly ROWS rows. The stimulus writes thresholds only between frames, when both instances are idle, and always sends whole frames. `o_ready` is randomised on each instance independently, so stalls land at arbitrary points in the scan. This includes stalls on the last column of a row and during the flush of the final row.

// File: rtl/cl_pkg.sv
package cl_pkg;

    localparam int PIX_W  = 3;
    localparam int SEED_W = 3;
    localparam int CLUS_W = 7;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_SCAN = 1'b1
    } seq_st_e;

    // centre pixel and its four edge-sharing neighbours
    typedef struct packed {
        logic [PIX_W-1:0] c;
        logic [PIX_W-1:0] n;
        logic [PIX_W-1:0] s;
        logic [PIX_W-1:0] w;
        logic [PIX_W-1:0] e;
    } cross_t;

    // brightest neighbour, ties go to n, then s, then w, then e
    function automatic logic [PIX_W-1:0] brightest(input cross_t x);
        logic [PIX_W-1:0] b;
        b = x.n;
        if (x.s > b) b = x.s;
        if (x.w > b) b = x.w;
        if (x.e > b) b = x.e;
        return b;
    endfunction

endpackage

// File: rtl/cl_rowstore.sv
module cl_rowstore
    import cl_pkg::*;
#(
    parameter int COLS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift,
    input  logic                  flush,
    input  logic                  clear,
    input  logic [COLS*PIX_W-1:0] row_in,
    output logic [COLS*PIX_W-1:0] row_up,
    output logic [COLS*PIX_W-1:0] row_mid,
    output logic [COLS*PIX_W-1:0] row_dn
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row_up  <= '0;
            row_mid <= '0;
            row_dn  <= '0;
        end else if (shift) begin
            row_up  <= row_mid;
            row_mid <= row_dn;
            row_dn  <= flush ? '0 : row_in;
        end
    end

    // R3
    store_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (row_up == '0 && row_mid == '0 && row_dn == '0));

endmodule

// File: rtl/cl_eval.sv
module cl_eval
    import cl_pkg::*;
#(
    parameter int COLS  = 8,
    parameter int COL_W = 3
) (
    input  logic [COLS*PIX_W-1:0] row_up,
    input  logic [COLS*PIX_W-1:0] row_mid,
    input  logic [COLS*PIX_W-1:0] row_dn,
    input  logic [COL_W-1:0]      col,
    input  logic [SEED_W-1:0]     seed_lvl,
    input  logic [CLUS_W-1:0]     clus_lvl,
    output logic                  hit,
    output cross_t                cr
);

    function automatic logic [PIX_W-1:0] pick(input logic [COLS*PIX_W-1:0] v, input int idx);
        if (idx < 0 || idx >= COLS) return '0;
        return v[idx*PIX_W +: PIX_W];
    endfunction

    logic [CLUS_W-1:0] sum;
    int                ci;

    always_comb begin
        ci   = int'(col);
        sum  = '0;
        for (int d = -1; d <= 1; d++) begin
            sum = sum + CLUS_W'(pick(row_up,  ci + d));
            sum = sum + CLUS_W'(pick(row_mid, ci + d));
            sum = sum + CLUS_W'(pick(row_dn,  ci + d));
        end
        cr.c = pick(row_mid, ci);
        cr.n = pick(row_up,  ci);
        cr.s = pick(row_dn,  ci);
        cr.w = pick(row_mid, ci - 1);
        cr.e = pick(row_mid, ci + 1);
        hit  = (cr.c >= seed_lvl) && (sum >= clus_lvl);
    end

endmodule

// File: rtl/cl_seq.sv
module cl_seq
    import cl_pkg::*;
#(
    parameter int ROWS  = 6,
    parameter int COLS  = 8,
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             adv,
    output logic             in_ready,
    output logic             scanning,
    output logic             shift,
    output logic             flush,
    output logic             clear,
    output logic [ROW_W-1:0] ctr_row,
    output logic [COL_W-1:0] col
);

    localparam int CNT_W = $clog2(ROWS + 1);

    seq_st_e          st;
    logic [CNT_W-1:0] rows_in;
    logic             acc, last_col, row_done, need_flush;

    always_comb begin
        in_ready   = (st == ST_LOAD);
        scanning   = (st == ST_SCAN);
        acc        = in_valid && in_ready;
        last_col   = (col == COL_W'(COLS - 1));
        row_done   = scanning && adv && last_col;
        clear      = row_done && (ctr_row == ROW_W'(ROWS - 1));
        need_flush = row_done && !clear && (rows_in == CNT_W'(ROWS));
        shift      = acc || need_flush;
        flush      = need_flush;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_LOAD;
            rows_in <= '0;
            ctr_row <= '0;
            col     <= '0;
        end else begin
            case (st)
                ST_LOAD: begin
                    if (acc) begin
                        rows_in <= rows_in + 1'b1;
                        if (rows_in != '0) begin
                            ctr_row <= ROW_W'(rows_in - 1'b1);
                            col     <= '0;
                            st      <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    if (adv) begin
                        if (!last_col) begin
                            col <= col + 1'b1;
                        end else if (clear) begin
                            rows_in <= '0;
                            st      <= ST_LOAD;
                        end else if (need_flush) begin
                            ctr_row <= ctr_row + 1'b1;
                            col     <= '0;
                        end else begin
                            st <= ST_LOAD;
                        end
                    end
                end
                default: st <= ST_LOAD;
            endcase
        end
    end

    // R4
    rows_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        rows_in <= CNT_W'(ROWS));

    // R4
    ctr_row_range_chk: assert property (@(posedge clk) disable iff (rst)
        ctr_row < ROW_W'(ROWS));

    // R8
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scanning && !adv) |=> ($stable(col) && $stable(ctr_row) && scanning));

endmodule

// File: rtl/cl_sparsifier.sv
module cl_sparsifier
    import cl_pkg::*;
#(
    parameter int ROWS    = 6,
    parameter int COLS    = 8,
    parameter bit REDUCED = 1'b0,
    parameter int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COL_W   = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int NPIX    = REDUCED ? 2 : 5,
    parameter int REC_W   = NPIX * PIX_W + ROW_W + COL_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic                  cfg_sel,
    input  logic [CLUS_W-1:0]     cfg_wdata,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [COLS*PIX_W-1:0] in_row,
    output logic                  o_valid,
    input  logic                  o_ready,
    output logic [REC_W-1:0]      o_rec
);

    localparam logic [SEED_W-1:0] SEED_RST = SEED_W'(4);
    localparam logic [CLUS_W-1:0] CLUS_RST = CLUS_W'(12);

    logic [SEED_W-1:0]     seed_q;
    logic [CLUS_W-1:0]     clus_q;
    logic [COLS*PIX_W-1:0] row_up, row_mid, row_dn;
    logic                  scanning, shift, flush, clear, adv, hit;
    logic [ROW_W-1:0]      ctr_row;
    logic [COL_W-1:0]      col;
    cross_t                cr;
    logic [REC_W-1:0]      rec;

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q <= SEED_RST;
            clus_q <= CLUS_RST;
        end else if (cfg_we) begin
            if (cfg_sel) clus_q <= cfg_wdata;
            else         seed_q <= cfg_wdata[SEED_W-1:0];
        end
    end

    assign adv = !o_valid || o_ready;

    cl_seq #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .adv(adv),
        .in_ready(in_ready), .scanning(scanning), .shift(shift),
        .flush(flush), .clear(clear), .ctr_row(ctr_row), .col(col)
    );

    cl_rowstore #(.COLS(COLS)) u_store (
        .clk(clk), .rst(rst), .shift(shift), .flush(flush), .clear(clear),
        .row_in(in_row), .row_up(row_up), .row_mid(row_mid), .row_dn(row_dn)
    );

    cl_eval #(.COLS(COLS), .COL_W(COL_W)) u_eval (
        .row_up(row_up), .row_mid(row_mid), .row_dn(row_dn), .col(col),
        .seed_lvl(seed_q), .clus_lvl(clus_q), .hit(hit), .cr(cr)
    );

    generate
        if (REDUCED) begin : g_reduced
            assign rec = {cr.c, brightest(cr), ctr_row, col};
        end else begin : g_full
            assign rec = {cr.c, cr.n, cr.s, cr.w, cr.e, ctr_row, col};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_rec   <= '0;
        end else if (adv) begin
            o_valid <= scanning && hit;
            o_rec   <= rec;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_rec)));

    // R2
    rec_seed_chk: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_rec[REC_W-1 -: PIX_W] >= seed_q));

    // R4
    rec_row_chk: assert property (@(posedge clk) disable iff (rst)
        o_valid |-> (o_rec[COL_W +: ROW_W] < ROW_W'(ROWS)));

endmodule

// File: tb/sim_cl_sparsifier.sv
`timescale 1ns/1ps
module sim_cl_sparsifier;

    localparam int ROWS   = 6;
    localparam int COLS   = 8;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int REC0_W = 5*3 + ROW_W + COL_W;
    localparam int REC1_W = 2*3 + ROW_W + COL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [6:0]       cfg_wdata = '0;
    logic             iv [2];
    logic             ir [2];
    logic [COLS*3-1:0] rrow [2];
    logic             ov [2];
    logic             rdy [2];
    logic [REC0_W-1:0] rec0;
    logic [REC1_W-1:0] rec1;

    int checks = 0;
    int fails  = 0;

    logic [2:0] fr [ROWS][COLS];
    logic [2:0] m_seed;
    logic [6:0] m_clus;
    logic [REC0_W-1:0] q0 [$];
    logic [REC1_W-1:0] q1 [$];

    cl_sparsifier #(.ROWS(ROWS), .COLS(COLS), .REDUCED(1'b0)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .in_valid(iv[0]), .in_ready(ir[0]), .in_row(rrow[0]),
        .o_valid(ov[0]), .o_ready(rdy[0]), .o_rec(rec0)
    );

    cl_sparsifier #(.ROWS(ROWS), .COLS(COLS), .REDUCED(1'b1)) u1 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .in_valid(iv[1]), .in_ready(ir[1]), .in_row(rrow[1]),
        .o_valid(ov[1]), .o_ready(rdy[1]), .o_rec(rec1)
    );

    function automatic logic [2:0] px(input int r, input int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 3'd0;
        return fr[r][c];
    endfunction

    function automatic int wsum(input int r, input int c);
        int s = 0;
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                s += int'(px(r + dr, c + dc));
        return s;
    endfunction

    task automatic build_expected(output int n);
        n = 0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                logic [2:0] cc, nn, ss, ww, ee, bb;
                cc = px(r, c); nn = px(r-1, c); ss = px(r+1, c);
                ww = px(r, c-1); ee = px(r, c+1);
                if (cc >= m_seed && wsum(r, c) >= int'(m_clus)) begin
                    bb = nn;
                    if (ss > bb) bb = ss;
                    if (ww > bb) bb = ww;
                    if (ee > bb) bb = ee;
                    q0.push_back({cc, nn, ss, ww, ee, ROW_W'(r), COL_W'(c)});
                    q1.push_back({cc, bb, ROW_W'(r), COL_W'(c)});
                    n++;
                end
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // output monitor with random stalls
    always @(negedge clk) begin
        if (rst) begin
            rdy[0] = 1'b1;
            rdy[1] = 1'b1;
        end else begin
            rdy[0] = ($urandom_range(0, 9) < 7);
            rdy[1] = ($urandom_range(0, 9) < 6);
            if (ov[0] && rdy[0]) begin
                if (q0.size() == 0) check(1'b0, "R4 u0 extra record", longint'(rec0), 0);
                else begin
                    logic [REC0_W-1:0] e0;
                    e0 = q0.pop_front();
                    check(rec0 === e0, "R5 u0 full record", longint'(rec0), longint'(e0));
                end
            end
            if (ov[1] && rdy[1]) begin
                if (q1.size() == 0) check(1'b0, "R4 u1 extra record", longint'(rec1), 0);
                else begin
                    logic [REC1_W-1:0] e1;
                    e1 = q1.pop_front();
                    check(rec1 === e1, "R6 u1 reduced record", longint'(rec1), longint'(e1));
                end
            end
        end
    end

    task automatic drive_frame(input int k);
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            for (int c = 0; c < COLS; c++) rrow[k][c*3 +: 3] = fr[r][c];
            iv[k] = 1'b1;
            while (!ir[k]) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        iv[k] = 1'b0;
    endtask

    task automatic run_frame(input string tag);
        int n;
        int w;
        build_expected(n);
        fork
            drive_frame(0);
            drive_frame(1);
        join
        w = 0;
        while ((q0.size() != 0 || q1.size() != 0) && w < 2000) begin
            @(negedge clk);
            w++;
        end
        repeat (ROWS*COLS*3 + 20) @(negedge clk);
        check(q0.size() == 0, {tag, " u0 all records delivered"}, q0.size(), 0);
        check(q1.size() == 0, {tag, " u1 all records delivered"}, q1.size(), 0);
        q0.delete();
        q1.delete();
    endtask

    task automatic write_thr(input logic sel, input logic [6:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_clus = v; else m_seed = v[2:0];
    endtask

    task automatic clear_frame();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) fr[r][c] = 3'd0;
    endtask

    task automatic random_frame();
        clear_frame();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if ($urandom_range(0, 99) < 8) begin
                    int v;
                    v = int'(fr[r][c]) + int'($urandom_range(4, 7));
                    fr[r][c] = (v > 7) ? 3'd7 : 3'(v);
                    for (int dr = -1; dr <= 1; dr++)
                        for (int dc = -1; dc <= 1; dc++)
                            if (r+dr >= 0 && r+dr < ROWS && c+dc >= 0 && c+dc < COLS &&
                                !(dr == 0 && dc == 0)) begin
                                v = int'(fr[r+dr][c+dc]) + int'($urandom_range(0, 2));
                                fr[r+dr][c+dc] = (v > 7) ? 3'd7 : 3'(v);
                            end
                end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        iv[0] = 1'b0; iv[1] = 1'b0;
        rrow[0] = '0; rrow[1] = '0;
        m_seed = 3'd4;
        m_clus = 7'd12;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(ov[0] == 1'b0, "R9 u0 o_valid after reset", ov[0], 0);
        check(ir[0] == 1'b1, "R9 u0 in_ready after reset", ir[0], 1);
        check(ov[1] == 1'b0, "R9 u1 o_valid after reset", ov[1], 0);
        check(ir[1] == 1'b1, "R9 u1 in_ready after reset", ir[1], 1);

        // R9 default levels, R3 corner, R2 boundary equality, R10 overlap
        clear_frame();
        fr[0][0] = 3'd4; fr[0][1] = 3'd4; fr[1][0] = 3'd4;
        fr[5][7] = 3'd3; fr[4][7] = 3'd7; fr[5][6] = 3'd7;
        run_frame("R9 R3 R10 default levels corner");

        // R2 one below cluster level: sum 11 with seed met
        clear_frame();
        fr[2][3] = 3'd4; fr[2][4] = 3'd4; fr[3][3] = 3'd3;
        run_frame("R2 sum one below level");

        // R7 write thresholds; R2 centre one below seed
        write_thr(1'b0, 7'd5);
        write_thr(1'b1, 7'd20);
        clear_frame();
        fr[2][2] = 3'd4; fr[1][2] = 3'd7; fr[3][2] = 3'd7; fr[2][1] = 3'd7;
        fr[3][5] = 3'd5; fr[2][5] = 3'd7; fr[4][5] = 3'd7; fr[3][6] = 3'd1;
        run_frame("R7 R2 written levels");

        // R4 every window accepted: full raster order, heavy stalls
        write_thr(1'b0, 7'd0);
        write_thr(1'b1, 7'd0);
        clear_frame();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) fr[r][c] = 3'((r*3 + c*5) % 8);
        run_frame("R4 R1 all windows");

        // R6 tie-breaking among equal neighbours
        clear_frame();
        fr[2][2] = 3'd6; fr[1][2] = 3'd5; fr[3][2] = 3'd5; fr[2][1] = 3'd5; fr[2][3] = 3'd5;
        write_thr(1'b0, 7'd6);
        write_thr(1'b1, 7'd1);
        run_frame("R6 tie order");

        // random frames, about 8 percent occupancy
        write_thr(1'b0, 7'd4);
        write_thr(1'b1, 7'd10);
        for (int f = 0; f < 30; f++) begin
            random_frame();
            run_frame("R2 R8 random frame");
        end

        summary();
        $finish;
    end

endmodule